// File: doc/BRIEF.md
# Dual Interval and Free-Running Timer

This block is a register-mapped timer peripheral with two counters behind one control word. The interval timer is a down-counter that software arms by writing a start value. It steps once per prescaled tick, raises an interrupt flag when it lands on zero, and restarts from a separate background reload value. The tick rate is a programmable base divider multiplied by a coarse scale of 1, 16 or 256. The counter runs either at its full 32 bits or with only its low 16 bits active.

The second counter is a 32-bit free-running up-counter. It has its own 8-bit divider and software can only read it. A debug-halt input can freeze both counters while a debugger holds the system. A control bit decides whether that input is honoured.

Software reaches the block through a single-cycle write port and a combinational read port, both word-indexed. It sees interrupts through one level output, which is the masked flag.

Top module: `gp_dual_timer`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: Word indexes are: 0 start value (a read returns the reload value), 1 current count, 2 control, 3 flag acknowledge (reads 0), 4 raw flag in bit 0, 5 masked flag in bit 0, 6 reload value, 7 base divider (10 bits), 8 free-running count. Other indexes read 0. Control keeps only bits 23:16, 9, 8, 7, 5, 3:2 and 1; the other bits read 0.
- R3: A write to index 0 sets both the count and the reload value at that clock edge and restarts the tick prescaler. This write wins over a tick in the same cycle.
- R4: With control bit 7 set, the count drops by one every (divider+1)×S clocks. S is selected by control bits 3:2: 00 gives 1, 01 gives 16, and 10 or 11 give 256.
- R5: A tick that takes the active count from 1 to 0 sets the raw flag. The next tick, finding zero, copies the reload value into the count.
- R6: Control bit 1 selects the width. At 0, only bits 15:0 decrement and are tested for zero, and bits 31:16 hold. At 1, all 32 bits are active.
- R7: A write of any value to index 3 clears the raw flag. A flag being set in the same cycle takes priority.
- R8: The masked flag and `irq` equal the raw flag AND control bit 5.
- R9: With control bit 7 clear, the count holds its value.
- R10: With control bit 9 set, the free-running count rises by one every (bits 23:16 + 1) clocks. It holds while bit 9 is clear, and writes to index 8 have no effect.
- R11: While control bit 8 and `dbg_halt` are both high, both counters and their prescalers freeze. With bit 8 clear, `dbg_halt` has no effect.
- R12: A write to index 6 changes only the reload value and leaves the running count untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_idx | input | 4 | Word index of the write |
| wr_data | input | 32 | Write data |
| rd_idx | input | 4 | Word index of the read |
| rd_data | output | 32 | Read data, combinational from `rd_idx` |
| dbg_halt | input | 1 | Debug freeze request |
| irq | output | 1 | Masked interrupt level |

## Verification
A write takes effect at the clock edge that samples `wr_en`, so readback is due half a cycle later. A start-value write restarts the prescaler, which puts the k-th tick exactly k×(divider+1)×S edges after the write edge. The free counter's first step comes (prescale+1) edges after its enable edge. The bench drives on falling edges and reads shortly after them. It counts edges from each write edge and samples both the last cycle before an expected change and the first cycle after it, so an off-by-one in any divider shows up.

// File: rtl/tmr_pkg.sv
`timescale 1ns/100ps
// Package tmr_pkg
// Shared register indexes, control-bit positions and the decoded control
// type for the dual timer. Assumes a 32-bit data word.
package tmr_pkg;
    localparam int unsigned WORD_W     = 32;
    localparam int unsigned IDX_W      = 4;
    localparam int unsigned FREE_PRE_W = 8;

    localparam logic [IDX_W-1:0] IDX_START  = 4'd0;
    localparam logic [IDX_W-1:0] IDX_COUNT  = 4'd1;
    localparam logic [IDX_W-1:0] IDX_CTRL   = 4'd2;
    localparam logic [IDX_W-1:0] IDX_ACK    = 4'd3;
    localparam logic [IDX_W-1:0] IDX_RAW    = 4'd4;
    localparam logic [IDX_W-1:0] IDX_MASKED = 4'd5;
    localparam logic [IDX_W-1:0] IDX_RELOAD = 4'd6;
    localparam logic [IDX_W-1:0] IDX_BDIV   = 4'd7;
    localparam logic [IDX_W-1:0] IDX_FREE   = 4'd8;

    localparam logic [WORD_W-1:0] CTRL_KEEP = 32'h00FF_03AE;

    typedef struct packed {
        logic [FREE_PRE_W-1:0] free_pre;
        logic                  free_en;
        logic                  halt_en;
        logic                  run_en;
        logic                  irq_en;
        logic [1:0]            scale;
        logic                  wide;
    } ctrl_t;
endpackage

// File: rtl/tmr_regfile.sv
`timescale 1ns/100ps
// Module tmr_regfile
// Holds the control word and the base divider, decodes register writes
// into one-cycle strobes for the counters, and muxes the read port.
// Assumes at most one write per cycle; reads are purely combinational.
module tmr_regfile
    import tmr_pkg::*;
#(
    parameter int unsigned BDIV_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_data,
    output ctrl_t             ctrl,
    output logic [BDIV_W-1:0] bdiv,
    output logic              start_wr,
    output logic              reload_wr,
    output logic              ack_wr,
    input  logic [WORD_W-1:0] cur_count,
    input  logic [WORD_W-1:0] reload_val,
    input  logic              raw_flag,
    input  logic [WORD_W-1:0] free_count
);
    logic [WORD_W-1:0] ctrl_q;

    // Write strobes for the registers that live in the counter modules.
    assign start_wr  = wr_en && (wr_idx == IDX_START);
    assign reload_wr = wr_en && (wr_idx == IDX_RELOAD);
    assign ack_wr    = wr_en && (wr_idx == IDX_ACK);

    // Control word and base divider storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            bdiv   <= '0;
        end else if (wr_en) begin
            if (wr_idx == IDX_CTRL) ctrl_q <= wr_data & CTRL_KEEP;
            if (wr_idx == IDX_BDIV) bdiv   <= wr_data[BDIV_W-1:0];
        end
    end

    // Split the stored control word into named fields.
    assign ctrl.free_pre = ctrl_q[23:16];
    assign ctrl.free_en  = ctrl_q[9];
    assign ctrl.halt_en  = ctrl_q[8];
    assign ctrl.run_en   = ctrl_q[7];
    assign ctrl.irq_en   = ctrl_q[5];
    assign ctrl.scale    = ctrl_q[3:2];
    assign ctrl.wide     = ctrl_q[1];

    // Read multiplexer.
    always_comb begin
        case (rd_idx)
            IDX_START:  rd_data = reload_val;
            IDX_COUNT:  rd_data = cur_count;
            IDX_CTRL:   rd_data = ctrl_q;
            IDX_RAW:    rd_data = {{(WORD_W-1){1'b0}}, raw_flag};
            IDX_MASKED: rd_data = {{(WORD_W-1){1'b0}}, raw_flag & ctrl_q[5]};
            IDX_RELOAD: rd_data = reload_val;
            IDX_BDIV:   rd_data = {{(WORD_W-BDIV_W){1'b0}}, bdiv};
            IDX_FREE:   rd_data = free_count;
            default:    rd_data = '0;
        endcase
    end

    a_r2_ctrl_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q & ~CTRL_KEEP) == '0);
endmodule

// File: rtl/tmr_interval.sv
`timescale 1ns/100ps
// Module tmr_interval
// Prescaled down-counter with start/reload values and a raw flag.
// The tick period is (bdiv+1) times 1, 16 or 256 clocks. A start write
// restarts the prescaler. In narrow mode only the low half counts.
// Assumes halt is already qualified by the control enable.
module tmr_interval #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned BDIV_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              halt,
    input  logic              wide,
    input  logic [1:0]        scale,
    input  logic [BDIV_W-1:0] bdiv,
    input  logic              start_wr,
    input  logic              reload_wr,
    input  logic              ack_wr,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] count,
    output logic [WORD_W-1:0] reload,
    output logic              raw
);
    localparam int unsigned SCALE_BITS = 8;
    localparam int unsigned PCNT_W     = BDIV_W + SCALE_BITS;
    localparam int unsigned HALF_W     = WORD_W / 2;

    logic [3:0]        shift;
    logic [PCNT_W:0]   span;
    logic [PCNT_W:0]   pcnt;
    logic [PCNT_W:0]   pcnt_nx;
    logic              tick;
    logic [WORD_W-1:0] active;
    logic              at_zero;
    logic              at_one;

    // Coarse scale selection: 1, 16, or 256 for both upper codes.
    always_comb begin
        case (scale)
            2'b00:   shift = 4'd0;
            2'b01:   shift = 4'd4;
            default: shift = 4'd8;
        endcase
    end

    // Full tick period in clocks and the prescaler's next value.
    assign span    = ({1'b0, {SCALE_BITS{1'b0}}, bdiv} + 1'b1) << shift;
    assign pcnt_nx = pcnt + 1'b1;
    assign tick    = en && !halt && (pcnt_nx == span);

    // Prescaler: restarts on a start write or while disabled, freezes on halt.
    always_ff @(posedge clk) begin
        if (!rst_n || start_wr || !en) pcnt <= '0;
        else if (!halt)                pcnt <= tick ? '0 : pcnt_nx;
    end

    // Active part of the count for the zero and one tests.
    assign active  = wide ? count : {{(WORD_W-HALF_W){1'b0}}, count[HALF_W-1:0]};
    assign at_zero = (active == '0);
    assign at_one  = (active == {{(WORD_W-1){1'b0}}, 1'b1});

    // Down-counter: start write, reload at zero, or decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)        count <= '0;
        else if (start_wr) count <= wr_data;
        else if (tick) begin
            if (at_zero)   count <= reload;
            else if (wide) count <= count - 1'b1;
            else           count <= {count[WORD_W-1:HALF_W], count[HALF_W-1:0] - 1'b1};
        end
    end

    // Background reload value, written by either start or reload index.
    always_ff @(posedge clk) begin
        if (!rst_n)                    reload <= '0;
        else if (start_wr || reload_wr) reload <= wr_data;
    end

    // Raw flag: set on the step into zero, cleared by acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)                raw <= 1'b0;
        else if (tick && at_one)   raw <= 1'b1;
        else if (ack_wr)           raw <= 1'b0;
    end

    a_r3_start_lands: assert property (@(posedge clk) disable iff (!rst_n)
        start_wr |=> (count == $past(wr_data)) && (reload == $past(wr_data)));
    a_r5_flag_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && at_one && !start_wr) |=> raw);
    a_r6_upper_half_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide && !start_wr && !(tick && at_zero)) |=> $stable(count[WORD_W-1:HALF_W]));
    a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && !tick) |=> !raw);
    a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !start_wr) |=> $stable(count));
    a_r11_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !start_wr) |=> $stable(count));
    a_r12_reload_only: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_wr && !start_wr && !tick) |=> $stable(count));
endmodule

// File: rtl/tmr_freerun.sv
`timescale 1ns/100ps
// Module tmr_freerun
// Free-running up-counter stepping once every (pre+1) clocks while
// enabled. It is read-only from outside and wraps naturally.
// Assumes halt is already qualified by the control enable.
module tmr_freerun #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned PRE_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              halt,
    input  logic [PRE_W-1:0]  pre,
    output logic [WORD_W-1:0] count
);
    logic [PRE_W-1:0] pcnt;
    logic             step;

    assign step = en && !halt && (pcnt == pre);

    // Divider: cleared while disabled, frozen while halted.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) pcnt <= '0;
        else if (!halt)    pcnt <= step ? '0 : pcnt + 1'b1;
    end

    // Counter advance.
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= '0;
        else if (step) count <= count + 1'b1;
    end

    a_r10_unit_steps: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (count == $past(count)) || (count == $past(count) + 1'b1));
    a_r10_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(count));
    a_r11_free_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> $stable(count));
endmodule

// File: rtl/gp_dual_timer.sv
`timescale 1ns/100ps
// Module gp_dual_timer
// Top of the dual timer: register file, interval down-counter and
// free-running counter, plus the debug-halt qualifier and the masked
// interrupt output. Assumes a single clock domain.
module gp_dual_timer
    import tmr_pkg::*;
#(
    parameter int unsigned BDIV_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_data,
    input  logic              dbg_halt,
    output logic              irq
);
    ctrl_t             ctrl;
    logic [BDIV_W-1:0] bdiv;
    logic              start_wr;
    logic              reload_wr;
    logic              ack_wr;
    logic [WORD_W-1:0] cur_count;
    logic [WORD_W-1:0] reload_val;
    logic              raw_flag;
    logic [WORD_W-1:0] free_count;
    logic              halt_q;

    // Debug freeze applies only when the control word allows it.
    assign halt_q = ctrl.halt_en && dbg_halt;
    // Interrupt output is the masked flag.
    assign irq    = raw_flag && ctrl.irq_en;

    tmr_regfile #(.BDIV_W(BDIV_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_data(rd_data),
        .ctrl(ctrl), .bdiv(bdiv),
        .start_wr(start_wr), .reload_wr(reload_wr), .ack_wr(ack_wr),
        .cur_count(cur_count), .reload_val(reload_val),
        .raw_flag(raw_flag), .free_count(free_count)
    );

    tmr_interval #(.WORD_W(WORD_W), .BDIV_W(BDIV_W)) u_intv (
        .clk(clk), .rst_n(rst_n),
        .en(ctrl.run_en), .halt(halt_q), .wide(ctrl.wide),
        .scale(ctrl.scale), .bdiv(bdiv),
        .start_wr(start_wr), .reload_wr(reload_wr), .ack_wr(ack_wr),
        .wr_data(wr_data),
        .count(cur_count), .reload(reload_val), .raw(raw_flag)
    );

    tmr_freerun #(.WORD_W(WORD_W), .PRE_W(FREE_PRE_W)) u_free (
        .clk(clk), .rst_n(rst_n),
        .en(ctrl.free_en), .halt(halt_q), .pre(ctrl.free_pre),
        .count(free_count)
    );

    a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.irq_en |-> !irq);
    a_r8_irq_follows_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.irq_en |-> (irq == raw_flag));
endmodule

// File: tb/sim_gp_dual_timer.sv
`timescale 1ns/100ps
// Directed bench for gp_dual_timer: one task per scenario.
module sim_gp_dual_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_idx = '0;
    logic [31:0] rd_data;
    logic        dbg_halt = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    localparam logic [31:0] C_WIDE = 32'h0000_0002;
    localparam logic [31:0] C_IRQ  = 32'h0000_0020;
    localparam logic [31:0] C_RUN  = 32'h0000_0080;
    localparam logic [31:0] C_HALT = 32'h0000_0100;
    localparam logic [31:0] C_FREE = 32'h0000_0200;

    gp_dual_timer u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
        .dbg_halt(dbg_halt), .irq(irq)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] idx, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] idx, output logic [31:0] data);
        rd_idx = idx;
        #0.2;
        data = rd_data;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        dbg_halt = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        wait_cyc(3);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        for (int i = 0; i < 9; i++) begin
            rd(4'(i), v);
            check("R1 register zero after reset", v, 32'h0);
        end
        check("R1 irq low after reset", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_map();
        logic [31:0] v;
        do_reset();
        wr(4'd2, 32'hFFFF_FFFF);
        rd(4'd2, v); check("R2 control keeps defined bits", v, 32'h00FF_03AE);
        wr(4'd2, 32'h0);
        wr(4'd7, 32'hFFFF_FFFF);
        rd(4'd7, v); check("R2 base divider is 10 bits", v, 32'h0000_03FF);
        wr(4'd3, 32'hFFFF_FFFF);
        rd(4'd3, v); check("R2 acknowledge reads zero", v, 32'h0);
        rd(4'd12, v); check("R2 unmapped index reads zero", v, 32'h0);
    endtask

    task automatic t_basic();
        logic [31:0] v;
        do_reset();
        wr(4'd2, C_RUN | C_WIDE | C_IRQ);
        wr(4'd0, 32'd5);
        rd(4'd1, v); check("R3 start value lands", v, 32'd5);
        rd(4'd0, v); check("R3 start also sets reload", v, 32'd5);
        wait_cyc(2);
        rd(4'd1, v); check("R4 one step per clock at scale 1", v, 32'd3);
        wait_cyc(2);
        rd(4'd4, v); check("R5 no flag before zero", v, 32'd0);
        wait_cyc(1);
        rd(4'd1, v); check("R5 count reaches zero", v, 32'd0);
        rd(4'd4, v); check("R5 raw flag set at zero", v, 32'd1);
        check("R8 irq high with enable", {31'b0, irq}, 32'd1);
        wait_cyc(1);
        rd(4'd1, v); check("R5 reload on next tick", v, 32'd5);
    endtask

    task automatic t_scale();
        logic [31:0] v;
        do_reset();
        wr(4'd2, C_RUN | C_WIDE | 32'h4);
        wr(4'd0, 32'd3);
        wait_cyc(15);
        rd(4'd1, v); check("R4 scale 16 holds before tick", v, 32'd3);
        wait_cyc(1);
        rd(4'd1, v); check("R4 scale 16 steps at 16", v, 32'd2);
        wr(4'd7, 32'd1);
        wr(4'd2, C_RUN | C_WIDE | 32'h8);
        wr(4'd0, 32'd2);
        wait_cyc(511);
        rd(4'd1, v); check("R4 divider 1 scale 256 holds", v, 32'd2);
        wait_cyc(1);
        rd(4'd1, v); check("R4 divider 1 scale 256 steps at 512", v, 32'd1);
        wr(4'd7, 32'd0);
        wr(4'd2, C_RUN | C_WIDE | 32'hC);
        wr(4'd0, 32'd1);
        wait_cyc(255);
        rd(4'd1, v); check("R4 code 11 holds before 256", v, 32'd1);
        wait_cyc(1);
        rd(4'd1, v); check("R4 code 11 steps at 256", v, 32'd0);
    endtask

    task automatic t_width();
        logic [31:0] v;
        do_reset();
        wr(4'd2, C_RUN);
        wr(4'd0, 32'h0003_0002);
        wait_cyc(2);
        rd(4'd1, v); check("R6 narrow mode zero on low half", v, 32'h0003_0000);
        rd(4'd4, v); check("R6 narrow zero raises flag", v, 32'd1);
        wait_cyc(1);
        rd(4'd1, v); check("R6 narrow reload", v, 32'h0003_0002);
        wr(4'd2, C_RUN | C_WIDE);
        wr(4'd0, 32'h0001_0000);
        wait_cyc(1);
        rd(4'd1, v); check("R6 wide mode borrows across halves", v, 32'h0000_FFFF);
    endtask

    task automatic t_flag();
        logic [31:0] v;
        do_reset();
        wr(4'd2, C_RUN | C_WIDE | C_IRQ);
        wr(4'd0, 32'd1);
        wr(4'd2, C_WIDE | C_IRQ);
        rd(4'd5, v); check("R8 masked flag with enable", v, 32'd1);
        check("R8 irq with enable", {31'b0, irq}, 32'd1);
        wr(4'd2, C_WIDE);
        rd(4'd4, v); check("R8 raw kept when masked", v, 32'd1);
        rd(4'd5, v); check("R8 masked flag off", v, 32'd0);
        check("R8 irq off when masked", {31'b0, irq}, 32'd0);
        wr(4'd3, 32'h0000_1234);
        rd(4'd4, v); check("R7 acknowledge clears raw", v, 32'd0);
    endtask

    task automatic t_idle();
        logic [31:0] v;
        do_reset();
        wr(4'd2, C_WIDE);
        wr(4'd0, 32'd7);
        wait_cyc(10);
        rd(4'd1, v); check("R9 disabled count holds", v, 32'd7);
    endtask

    task automatic t_reload();
        logic [31:0] v;
        do_reset();
        wr(4'd2, C_RUN | C_WIDE);
        wr(4'd0, 32'd10);
        wr(4'd6, 32'd3);
        rd(4'd1, v); check("R12 reload write leaves count", v, 32'd8);
        rd(4'd6, v); check("R12 reload value stored", v, 32'd3);
        wait_cyc(8);
        rd(4'd1, v); check("R12 count reaches zero", v, 32'd0);
        wait_cyc(1);
        rd(4'd1, v); check("R12 new reload used", v, 32'd3);
    endtask

    task automatic t_free();
        logic [31:0] v;
        logic [31:0] held;
        do_reset();
        wr(4'd2, C_FREE | 32'h0003_0000);
        wait_cyc(3);
        rd(4'd8, v); check("R10 no step before prescale", v, 32'd0);
        wait_cyc(1);
        rd(4'd8, v); check("R10 first step after 4 clocks", v, 32'd1);
        wait_cyc(8);
        rd(4'd8, v); check("R10 three steps after 12 clocks", v, 32'd3);
        wr(4'd2, 32'h0);
        rd(4'd8, held); check("R10 value at disable", held, 32'd3);
        wait_cyc(10);
        rd(4'd8, v); check("R10 holds when disabled", v, held);
        wr(4'd8, 32'hABCD);
        rd(4'd8, v); check("R10 write to free count ignored", v, held);
    endtask

    task automatic t_halt();
        logic [31:0] v;
        logic [31:0] f0;
        do_reset();
        wr(4'd2, C_RUN | C_WIDE | C_HALT | C_FREE);
        wr(4'd0, 32'd100);
        dbg_halt = 1'b1;
        rd(4'd8, f0);
        wait_cyc(5);
        rd(4'd1, v); check("R11 interval frozen by halt", v, 32'd100);
        rd(4'd8, v); check("R11 free count frozen by halt", v, f0);
        wr(4'd2, C_RUN | C_WIDE | C_FREE);
        rd(4'd1, v); check("R11 frozen through control write", v, 32'd100);
        wait_cyc(3);
        rd(4'd1, v); check("R11 halt ignored without enable", v, 32'd97);
        dbg_halt = 1'b0;
    endtask

    initial begin
        t_reset();
        t_map();
        t_basic();
        t_scale();
        t_width();
        t_flag();
        t_idle();
        t_reload();
        t_free();
        t_halt();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #500000;
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule